// File: doc/BRIEF.md
# I2C Indexed Block-Transfer Configuration Register Target

This block is an I2C target that owns a small bank of byte-wide configuration registers. All register contents appear in parallel on one output vector, so neighbouring logic can use the settings directly. The block has no bus clock of its own. It oversamples SCL and SDA in the system clock domain through two-flop synchronisers. It detects START, repeated START and STOP, matches its 7-bit address, shifts bytes in and out, and pulls SDA low through an open-drain drive-enable.

A write transfer carries a starting index and then an explicit byte count, followed by the data bytes. A read transfer first sets the index with a write-addressed header. The host then issues a repeated START with the read address. The target answers with the value held in the count register, then with the register contents from the index onward. An auto-incrementing pointer walks the bank and wraps at its end.

Top module: `i2cx_regslave`

## Requirements
- R1: After reset, register i holds 0x30+i, except register CNT_IDX, which holds DFLT_COUNT. Register i appears on regs_o[8i+7:8i]. sda_oe is low.
- R2: An address byte whose upper seven bits equal DEV_ADDR (default 0x69, so 0xD2 to write and 0xD3 to read) is acknowledged. Any other address gets no acknowledge, and the target drives nothing and changes nothing until the next START. SDA drive changes only while SCL is low.
- R3: In a write, the index byte, the count byte and every data byte within the count are acknowledged. Data byte k is stored in register index+k.
- R4: Inside the bank, the pointer steps from NUM_REGS-1 back to 0, for both writes and reads.
- R5: A data byte written at an index of NUM_REGS or above is acknowledged and discarded. Reading such an index returns 0x00. An out-of-range pointer increments modulo 256.
- R6: Data bytes beyond the written count are not acknowledged and not stored. The target then stays idle until the next START.
- R7: In a read, the first byte returned is the count register, followed by the registers from the index onward.
- R8: A value written to register CNT_IDX becomes the count returned by every later read.
- R9: When the host does not acknowledge a read byte, the target releases SDA and stays released until the next START.
- R10: A STOP or START in the middle of a transfer ends it. Registers written before that point keep their new values, and the next transfer behaves normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| regs_o | output | NUM_REGS*8 | All registers; register i occupies bits [8i+7:8i] |

## Verification
The bench builds the block with a 12-entry bank, the count register at index 8 and a default count of 3. With these values a four-byte burst from index 10 crosses the wrap point, and indices 0xF0 and 0xFE give out-of-range writes and reads next to the 8-bit pointer rollover. A count of 3 also lets a later write of 5 to the count register show up as a different read length. The host model drives SDA through a wired-AND with sda_oe and samples the line in the middle of each SCL high phase. This is how acknowledges and returned bytes are observed.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACK_SETUP, S_ACK_HOLD, S_TX, S_HACK
  } link_state_t;

  typedef enum logic [1:0] {
    B_ADDR, B_INDEX, B_COUNT, B_DATA
  } rx_role_t;

  // Pointer advance: wraps inside the bank, free-runs modulo 256 outside it.
  function automatic logic [7:0] step_ptr(input logic [7:0] p, input int unsigned nregs);
    if (32'(p) == nregs - 32'd1) return 8'd0;
    return p + 8'd1;
  endfunction

  function automatic logic [7:0] boot_value(input int unsigned idx, input int unsigned cnt_idx,
                                            input logic [7:0] cnt_val);
    if (idx == cnt_idx) return cnt_val;
    return 8'h30 + 8'(idx);
  endfunction

  function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

endpackage

// File: rtl/i2cx_line_sync.sv
module i2cx_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // [0] first flop, [1] synchronised, [2] previous synchronised value
  logic [2:0] scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign scl_s     = scl_q[1];
  assign sda_s     = sda_q[1];
  assign scl_rise  = scl_q[1] & ~scl_q[2];
  assign scl_fall  = ~scl_q[1] & scl_q[2];
  assign start_det = scl_q[1] & scl_q[2] & ~sda_q[1] & sda_q[2];
  assign stop_det  = scl_q[1] & scl_q[2] & sda_q[1] & ~sda_q[2];

endmodule

// File: rtl/i2cx_regfile.sv
module i2cx_regfile import i2cx_pkg::*; #(
  parameter int unsigned NUM_REGS   = 16,
  parameter int unsigned CNT_IDX    = 8,
  parameter logic [7:0]  DFLT_COUNT = 8'd4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [7:0]            widx,
  input  logic [7:0]            wdata,
  input  logic [7:0]            ridx,
  output logic [7:0]            rdata,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int unsigned IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [7:0] mem [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        mem[g] <= boot_value(g, CNT_IDX, DFLT_COUNT);
      else if (we && widx == 8'(g))      mem[g] <= wdata;
    end
    assign regs_o[g*8 +: 8] = mem[g];
  end

  assign rdata = (32'(ridx) < NUM_REGS) ? mem[ridx[IW-1:0]] : 8'h00;

  // R5: a write aimed outside the bank leaves every register untouched
  assert_discard_out_of_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && 32'(widx) >= NUM_REGS) |=> $stable(regs_o));

endmodule

// File: rtl/i2cx_regslave.sv
module i2cx_regslave import i2cx_pkg::*; #(
  parameter logic [6:0]  DEV_ADDR   = 7'h69,
  parameter int unsigned NUM_REGS   = 16,
  parameter int unsigned CNT_IDX    = 8,
  parameter logic [7:0]  DFLT_COUNT = 8'd4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  link_state_t st;
  rx_role_t    role;
  logic [2:0]  bitcnt;
  logic [6:0]  shreg, txsh;
  logic [7:0]  ptr, remain;
  logic        ack_go, go_tx;

  // Named internal events
  logic       byte_done, dec_ack, wr_en, ptr_adv, tx_first_load, tx_next_load;
  logic [7:0] rx_byte, rdata, tx_byte, count_val;

  i2cx_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cx_regfile #(.NUM_REGS(NUM_REGS), .CNT_IDX(CNT_IDX), .DFLT_COUNT(DFLT_COUNT)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .widx(ptr), .wdata(rx_byte),
    .ridx(ptr), .rdata(rdata), .regs_o(regs_o)
  );

  assign byte_done     = (st == S_RX) && scl_rise && (bitcnt == 3'd7);
  assign rx_byte       = {shreg, sda_s};
  assign count_val     = regs_o[CNT_IDX*8 +: 8];
  assign tx_first_load = (st == S_ACK_HOLD) && scl_fall && go_tx;
  assign tx_next_load  = (st == S_HACK) && scl_fall;
  assign tx_byte       = tx_first_load ? count_val : rdata;
  assign ptr_adv       = wr_en || tx_next_load;

  always_comb begin
    dec_ack = 1'b0;
    wr_en   = 1'b0;
    if (byte_done) begin
      unique case (role)
        B_ADDR:           dec_ack = addr_hit(rx_byte, DEV_ADDR);
        B_INDEX, B_COUNT: dec_ack = 1'b1;
        B_DATA: begin
          dec_ack = (remain != 8'd0);
          wr_en   = (remain != 8'd0);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      role   <= B_ADDR;
      bitcnt <= 3'd0;
      shreg  <= 7'd0;
      txsh   <= 7'd0;
      ptr    <= 8'd0;
      remain <= 8'd0;
      ack_go <= 1'b0;
      go_tx  <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      st     <= S_RX;
      role   <= B_ADDR;
      bitcnt <= 3'd0;
      go_tx  <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else begin
      if (ptr_adv) ptr <= step_ptr(ptr, NUM_REGS);
      unique case (st)
        S_RX: if (scl_rise) begin
          shreg  <= rx_byte[6:0];
          bitcnt <= bitcnt + 3'd1;
          if (bitcnt == 3'd7) begin
            st     <= S_ACK_SETUP;
            ack_go <= dec_ack;
            unique case (role)
              B_ADDR:  begin go_tx <= rx_byte[0]; role <= B_INDEX; end
              B_INDEX: begin ptr <= rx_byte; role <= B_COUNT; end
              B_COUNT: begin remain <= rx_byte; role <= B_DATA; end
              B_DATA:  if (remain != 8'd0) remain <= remain - 8'd1;
            endcase
          end
        end
        S_ACK_SETUP: if (scl_fall) begin
          if (ack_go) begin
            sda_oe <= 1'b1;
            st     <= S_ACK_HOLD;
          end else begin
            st     <= S_IDLE;
          end
        end
        S_ACK_HOLD: if (scl_fall) begin
          bitcnt <= 3'd0;
          if (go_tx) begin
            txsh   <= tx_byte[6:0];
            sda_oe <= ~tx_byte[7];
            go_tx  <= 1'b0;
            st     <= S_TX;
          end else begin
            sda_oe <= 1'b0;
            st     <= S_RX;
          end
        end
        S_TX: if (scl_fall) begin
          if (bitcnt == 3'd7) begin
            sda_oe <= 1'b0;
            bitcnt <= 3'd0;
            st     <= S_HACK;
          end else begin
            sda_oe <= ~txsh[6];
            txsh   <= {txsh[5:0], 1'b0};
            bitcnt <= bitcnt + 3'd1;
          end
        end
        S_HACK: begin
          if (scl_rise && sda_s) begin
            st <= S_IDLE;
          end else if (scl_fall) begin
            txsh   <= tx_byte[6:0];
            sda_oe <= ~tx_byte[7];
            st     <= S_TX;
          end
        end
        default: ;
      endcase
    end
  end

  // R2: SDA drive only changes while SCL is low (bus events excepted)
  assert_oe_quiet_scl_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_det || stop_det)) |-> $stable(sda_oe));

  // R9: an idle target never pulls the line
  assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

  // R4: the pointer returns to zero after the last bank entry
  assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_adv && 32'(ptr) == NUM_REGS - 32'd1) |=> (ptr == 8'd0));

  // R6: nothing is stored once the count is used up
  assert_no_write_past_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (role == B_DATA && remain == 8'd0) |-> !wr_en);

endmodule

// File: tb/tb_i2cx_regslave.sv
module tb_i2cx_regslave;
  localparam int NREG = 12;
  localparam int CIDX = 8;
  localparam logic [7:0] DCNT = 8'd3;
  localparam int Q = 10;

  typedef struct packed {
    logic        rd;
    logic [7:0]  idx;
    logic [7:0]  cnt;
    logic [2:0]  nb;
    logic [31:0] data;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 8'h02, 8'd3, 3'd3, 32'h11223300},  // R3 plain write
    '{1'b1, 8'h02, 8'd0, 3'd0, 32'h0},         // R7 read back, count first
    '{1'b0, 8'h0A, 8'd4, 3'd4, 32'hA1A2A3A4},  // R4 write across wrap
    '{1'b0, 8'h08, 8'd1, 3'd1, 32'h05000000},  // R8 new count value
    '{1'b1, 8'h0A, 8'd0, 3'd0, 32'h0},         // R8 and R4 longer read across wrap
    '{1'b0, 8'hF0, 8'd2, 3'd2, 32'h77880000},  // R5 out-of-range write
    '{1'b1, 8'hFE, 8'd0, 3'd0, 32'h0}          // R5 out-of-range read, 8-bit rollover
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_h = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] regs_o;
  wire  sda_w = sda_h & ~sda_oe;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model [NREG];

  always #10 clk = ~clk;

  i2cx_regslave #(.DEV_ADDR(7'h69), .NUM_REGS(NREG), .CNT_IDX(CIDX), .DFLT_COUNT(DCNT)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_w), .sda_oe(sda_oe), .regs_o(regs_o)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] nxt(input logic [7:0] p);
    return (int'(p) == NREG - 1) ? 8'd0 : p + 8'd1;
  endfunction

  function automatic logic [7:0] rd_exp(input logic [7:0] p);
    return (int'(p) < NREG) ? model[p[3:0]] : 8'h00;
  endfunction

  function automatic logic [NREG*8-1:0] flat_model();
    logic [NREG*8-1:0] f;
    for (int i = 0; i < NREG; i++) f[i*8 +: 8] = model[i];
    return f;
  endfunction

  task automatic bus_start();
    if (!scl) begin sda_h = 1'b1; tick(Q); scl = 1'b1; tick(Q); end
    sda_h = 1'b0; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; tick(Q); scl = 1'b1; tick(Q); sda_h = 1'b1; tick(2*Q);
  endtask

  task automatic clock_bit(input logic b, output logic seen);
    sda_h = b; tick(Q); scl = 1'b1; tick(Q); seen = sda_w; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
    clock_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic host_ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin clock_bit(1'b1, s); b[i] = s; end
    clock_bit(!host_ack, s);
  endtask

  // Header of index and count; data bytes past the count expect no acknowledge.
  task automatic do_write(input logic [7:0] idx, input logic [7:0] cnt, input int nb,
                          input logic [31:0] data, input string req, input bit do_stop);
    logic a;
    logic [7:0] p;
    bus_start();
    send_byte(8'hD2, a); check({req, " write address ack"}, a, 1'b1);
    send_byte(idx, a);   check({req, " index ack"}, a, 1'b1);
    send_byte(cnt, a);   check({req, " count ack"}, a, 1'b1);
    p = idx;
    for (int k = 0; k < nb; k++) begin
      send_byte(data[31-8*k -: 8], a);
      check({req, " data ack"}, a, (k < int'(cnt)));
      if (k < int'(cnt)) begin
        if (int'(p) < NREG) model[p[3:0]] = data[31-8*k -: 8];
        p = nxt(p);
      end
    end
    if (do_stop) bus_stop();
  endtask

  task automatic do_read(input logic [7:0] idx, input string req);
    logic a;
    logic [7:0] b, p, c;
    bus_start();
    send_byte(8'hD2, a); check({req, " write address ack"}, a, 1'b1);
    send_byte(idx, a);   check({req, " index ack"}, a, 1'b1);
    bus_start();
    send_byte(8'hD3, a); check({req, " read address ack (R2)"}, a, 1'b1);
    c = model[CIDX];
    recv_byte(b, c != 8'd0);
    check({req, " count byte (R7)"}, b, c);
    p = idx;
    for (int k = 0; k < int'(c); k++) begin
      recv_byte(b, k < int'(c) - 1);
      check({req, " read data"}, b, rd_exp(p));
      p = nxt(p);
    end
    bus_stop();
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    logic a, s, all_hi;
    logic [7:0] b;
    for (int i = 0; i < NREG; i++) model[i] = (i == CIDX) ? DCNT : 8'h30 + 8'(i);
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R1: reset contents and released line
    check("R1 reset registers", regs_o, flat_model());
    check("R1 reset sda_oe", sda_oe, 1'b0);

    // Vector table
    for (int v = 0; v < 7; v++) begin
      if (VECS[v].rd) begin
        do_read(VECS[v].idx, $sformatf("R7 vector %0d", v));
      end else begin
        do_write(VECS[v].idx, VECS[v].cnt, int'(VECS[v].nb), VECS[v].data,
                 $sformatf("R3 vector %0d", v), 1'b1);
        check($sformatf("R3 vector %0d registers", v), regs_o, flat_model());
      end
    end

    // R2: foreign address is ignored until the next START
    bus_start();
    send_byte(8'hA0, a); check("R2 foreign address nack", a, 1'b0);
    send_byte(8'h03, a); check("R2 ignored follow-on byte", a, 1'b0);
    bus_stop();
    check("R2 registers unchanged", regs_o, flat_model());

    // R6: surplus bytes beyond the count
    do_write(8'h04, 8'd1, 3, 32'h5A6B7C00, "R6", 1'b1);
    check("R6 registers", regs_o, flat_model());

    // R10: STOP in mid-burst keeps earlier bytes, then a normal write
    do_write(8'h06, 8'd3, 2, 32'h01020000, "R10 stop-abort", 1'b1);
    check("R10 after stop abort", regs_o, flat_model());
    do_write(8'h00, 8'd1, 1, 32'h9C000000, "R10 after stop", 1'b1);
    check("R10 write after stop", regs_o, flat_model());

    // R10: repeated START in mid-burst, then a full write
    do_write(8'h03, 8'd2, 1, 32'hC3000000, "R10 start-abort", 1'b0);
    do_write(8'h09, 8'd1, 1, 32'hD9000000, "R10 after restart", 1'b1);
    check("R10 after restart abort", regs_o, flat_model());

    // R9: host NACK on first data byte, line must stay released
    bus_start();
    send_byte(8'hD2, a); check("R9 address ack", a, 1'b1);
    send_byte(8'h01, a); check("R9 index ack", a, 1'b1);
    bus_start();
    send_byte(8'hD3, a); check("R9 read address ack", a, 1'b1);
    recv_byte(b, 1'b1);  check("R9 count byte", b, model[CIDX]);
    recv_byte(b, 1'b0);  check("R9 data byte", b, model[1]);
    all_hi = 1'b1;
    for (int i = 0; i < 9; i++) begin
      clock_bit(1'b1, s);
      all_hi &= s;
    end
    check("R9 line released after NACK", all_hi, 1'b1);
    check("R9 sda_oe low", sda_oe, 1'b0);
    bus_stop();

    // R9/R7: a new START is served normally afterwards
    do_read(8'h00, "R9 read after nack");

    report();
  end

endmodule